// File: doc/BRIEF.md
# Address-Space-Tagged I/O Translation Cache

This block caches recent page translations for a 32-bit I/O virtual address space with 4 KB pages. Each line holds a virtual page number and an address-space identifier as its tag, plus a physical frame number and three permission bits: read, write and nonsecure. One requester presents a page number and an address-space identifier. In the same cycle the block answers with hit or miss, and on a hit it also returns the frame number and the permission bits.

On a miss the block raises a walk request toward an external table walker. The request carries the missed page number and its identifier. It holds that request until a fill comes back, and then writes the fill into a line. A fill goes into the lowest free active line. When no active line is free, it replaces a line chosen by a rotating pointer.

Software-style invalidation arrives as a 32-bit command word on a write strobe. The command can match every line, one 4 MB section, or one 16 KB group, and it can also be limited to lines of a single identifier. A configuration input sets how many lines are active; a value of zero or above the line count means all lines. A second input lets hits continue while a miss is outstanding.

Top module: `iotlb_asid`

## Requirements
- R1: A lookup whose page number and identifier equal those of a valid active line reports lk_hit in the same cycle, with that line's frame number and permission bits {read, write, nonsecure} on lk_attr[2:0]. Any other lookup reports lk_miss. lk_hit and lk_miss are never high together.
- R2: A missing lookup while no walk is outstanding raises fr_valid on the next cycle, with fr_vpn and fr_asid equal to the missed tag. The request stays high and unchanged until fill_valid. The fill then retires the request and installs the tag with fill_pfn and fill_attr.
- R3: While a walk is outstanding, lookups of cached tags hit when cfg_hit_under_miss is 1. When it is 0, every lookup reports a miss. In both cases a further miss does not replace the outstanding request.
- R4: Command bits [1:0] = 0 with bit 31 clear invalidates every line.
- R5: Command bits [1:0] = 2 invalidates the lines whose page number bits [19:10] (virtual address bits [31:22]) equal command bits [19:10].
- R6: Command bits [1:0] = 3 invalidates the lines whose page number bits [19:2] (virtual address bits [31:14]) equal command bits [19:2].
- R7: Command bit 31 set limits any invalidation to lines whose identifier equals the command's identifier field. That field is bits [30:24] in the default 7-bit configuration and bits [30:29] in the 2-bit configuration. Lines of other identifiers survive.
- R8: A command with bits [1:0] = 1 changes no line.
- R9: A command written in cycle t does not affect lookups in cycle t. Lookups from cycle t+1 onward no longer hit the invalidated lines.
- R10: A fill that arrives in cycle t+1 after a command whose match covers the outstanding tag is discarded; the request still retires. A fill whose tag the command does not cover is installed.
- R11: With N active lines, a fill takes the lowest-numbered free line below N. Otherwise it replaces the line at a rotating pointer that starts at line 0 and wraps at N. Only N tags are ever held at once.
- R12: After reset no lookup hits and no walk request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_active_lines | input | CNT_W | Number of lines that may be used (0 or above NUM_LINES means all) |
| cfg_hit_under_miss | input | 1 | Allow hits while a walk is outstanding |
| lk_valid | input | 1 | Lookup strobe |
| lk_vpn | input | 20 | Lookup virtual page number (address bits [31:12]) |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_pfn | output | PFN_W | Frame number of the hit line |
| lk_attr | output | 3 | {read, write, nonsecure} of the hit line |
| fr_valid | output | 1 | Walk request outstanding |
| fr_vpn | output | 20 | Page number to walk |
| fr_asid | output | ASID_W | Identifier to walk |
| fill_valid | input | 1 | Walk result strobe |
| fill_pfn | input | PFN_W | Walk result frame number |
| fill_attr | input | 3 | Walk result permission bits |
| cmd_we | input | 1 | Invalidation command strobe |
| cmd_wdata | input | 32 | Invalidation command word |

## Verification
The active line count is swept over every value from 1 to 8. For each count the bench fills two pages more than the count, so the surviving set shows both the free-line rule and the rotating pointer's wrap point. The invalidation tests use one set of six tags chosen so that pairs share a group, a section, or a page number with different identifiers. Each match mode and each identifier restriction then removes a different subset of those tags. Separate runs time a command against a lookup and against a fill in adjacent cycles, and they toggle the hit-under-miss input while a walk is outstanding.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
   localparam int VA_W       = 32;
   localparam int PAGE_SHIFT = 12;
   localparam int VPN_W      = VA_W - PAGE_SHIFT;
   localparam int ATTR_W     = 3;
   // field boundaries expressed as page-number bit positions
   localparam int SECT_LSB   = 22 - PAGE_SHIFT;
   localparam int GROUP_LSB  = 14 - PAGE_SHIFT;

   typedef enum logic [1:0] {
      FL_ANY     = 2'd0,
      FL_RSVD    = 2'd1,
      FL_SECTION = 2'd2,
      FL_GROUP   = 2'd3
   } fl_mode_e;

   function automatic int asid_width(input bit wide);
      return wide ? 7 : 2;
   endfunction
endpackage

// File: rtl/iotlb_flush_decode.sv
module iotlb_flush_decode
   import iotlb_pkg::*;
#(
   parameter int ASID_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [31:0]       cmd_wdata,
   output logic              fl_act,
   output logic [VPN_W-1:0]  fl_key,
   output logic [VPN_W-1:0]  fl_mask,
   output logic              fl_asid_chk,
   output logic [ASID_W-1:0] fl_asid
);
   localparam int ASID_LSB = 31 - ASID_W;

   logic [ASID_W-1:0] asid_field;
   fl_mode_e          mode_q;
   logic              unused_bits;

   if (ASID_W == 7) begin : g_wide_field
      assign asid_field = cmd_wdata[30:24];
   end else if (ASID_W == 2) begin : g_narrow_field
      assign asid_field = cmd_wdata[30:29];
   end else begin : g_bad_field
      $error("iotlb_flush_decode: ASID_W must be 2 or 7");
   end

   assign unused_bits = ^cmd_wdata[ASID_LSB-1:VPN_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_act      <= 1'b0;
         fl_asid_chk <= 1'b0;
         fl_asid     <= '0;
         fl_key      <= '0;
         mode_q      <= FL_ANY;
      end else begin
         fl_act <= cmd_we && (fl_mode_e'(cmd_wdata[1:0]) != FL_RSVD);
         if (cmd_we) begin
            mode_q      <= fl_mode_e'(cmd_wdata[1:0]);
            fl_key      <= cmd_wdata[VPN_W-1:0];
            fl_asid_chk <= cmd_wdata[31];
            fl_asid     <= asid_field;
         end
      end
   end

   always_comb begin
      case (mode_q)
         FL_SECTION: fl_mask = {{(VPN_W-SECT_LSB){1'b1}},  {SECT_LSB{1'b0}}};
         FL_GROUP:   fl_mask = {{(VPN_W-GROUP_LSB){1'b1}}, {GROUP_LSB{1'b0}}};
         default:    fl_mask = '0;
      endcase
   end
endmodule

// File: rtl/iotlb_victim_sel.sv
module iotlb_victim_sel #(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3,
   parameter int CNT_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_valid,
   input  logic [CNT_W-1:0]     eff_lines,
   input  logic                 alloc,
   output logic [IDX_W-1:0]     victim
);
   logic [IDX_W-1:0] rr_ptr;
   logic [IDX_W-1:0] rr_base;
   logic [IDX_W-1:0] free_idx;
   logic             have_free;
   logic [CNT_W-1:0] rr_next;

   always_comb begin
      have_free = 1'b0;
      free_idx  = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (!line_valid[i] && (CNT_W'(i) < eff_lines)) begin
            have_free = 1'b1;
            free_idx  = IDX_W'(i);
         end
      end
   end

   assign rr_base = (CNT_W'(rr_ptr) >= eff_lines) ? '0 : rr_ptr;
   assign rr_next = CNT_W'(rr_base) + CNT_W'(1);
   assign victim  = have_free ? free_idx : rr_base;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_ptr <= '0;
      end else if (alloc && !have_free) begin
         rr_ptr <= (rr_next >= eff_lines) ? '0 : IDX_W'(rr_next);
      end
   end
endmodule

// File: rtl/iotlb_asid.sv
module iotlb_asid
   import iotlb_pkg::*;
#(
   parameter  int NUM_LINES = 8,
   parameter  bit WIDE_ASID = 1'b1,
   parameter  int PFN_W     = 20,
   localparam int ASID_W    = asid_width(WIDE_ASID),
   localparam int CNT_W     = $clog2(NUM_LINES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_active_lines,
   input  logic              cfg_hit_under_miss,
   input  logic              lk_valid,
   input  logic [19:0]       lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic [2:0]        lk_attr,
   output logic              fr_valid,
   output logic [19:0]       fr_vpn,
   output logic [ASID_W-1:0] fr_asid,
   input  logic              fill_valid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [2:0]        fill_attr,
   input  logic              cmd_we,
   input  logic [31:0]       cmd_wdata
);
   localparam int IDX_W = $clog2(NUM_LINES);

   if (NUM_LINES < 2 || NUM_LINES > 64) begin : g_bad_lines
      $error("iotlb_asid: NUM_LINES must lie in 2..64");
   end
   if (PFN_W < 1 || PFN_W > 32) begin : g_bad_pfn
      $error("iotlb_asid: PFN_W must lie in 1..32");
   end

   // line storage
   logic [NUM_LINES-1:0] v_q;
   logic [VPN_W-1:0]     tag_vpn_q  [NUM_LINES];
   logic [ASID_W-1:0]    tag_asid_q [NUM_LINES];
   logic [PFN_W-1:0]     pfn_q      [NUM_LINES];
   logic [ATTR_W-1:0]    attr_q     [NUM_LINES];

   // outstanding walk
   logic              pend_q;
   logic [VPN_W-1:0]  pend_vpn_q;
   logic [ASID_W-1:0] pend_asid_q;

   // invalidation command
   logic              fl_act;
   logic [VPN_W-1:0]  fl_key;
   logic [VPN_W-1:0]  fl_mask;
   logic              fl_asid_chk;
   logic [ASID_W-1:0] fl_asid;

   logic [CNT_W-1:0]     eff_lines;
   logic [NUM_LINES-1:0] in_range;
   logic [NUM_LINES-1:0] kill;
   logic [NUM_LINES-1:0] match;
   logic [IDX_W-1:0]     victim;
   logic                 any_hit;
   logic                 start_miss;
   logic                 fill_take;
   logic                 fill_killed;
   logic                 install;

   iotlb_flush_decode #(.ASID_W(ASID_W)) u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_we      (cmd_we),
      .cmd_wdata   (cmd_wdata),
      .fl_act      (fl_act),
      .fl_key      (fl_key),
      .fl_mask     (fl_mask),
      .fl_asid_chk (fl_asid_chk),
      .fl_asid     (fl_asid)
   );

   assign eff_lines = ((cfg_active_lines == '0) || (cfg_active_lines > CNT_W'(NUM_LINES)))
                      ? CNT_W'(NUM_LINES) : cfg_active_lines;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign in_range[i] = CNT_W'(i) < eff_lines;
      assign kill[i]     = fl_act && v_q[i]
                           && ((tag_vpn_q[i] & fl_mask) == (fl_key & fl_mask))
                           && (!fl_asid_chk || (tag_asid_q[i] == fl_asid));
      assign match[i]    = v_q[i] && !kill[i] && in_range[i]
                           && (tag_vpn_q[i] == lk_vpn) && (tag_asid_q[i] == lk_asid);
   end

   always_comb begin
      lk_pfn  = '0;
      lk_attr = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (match[i]) begin
            lk_pfn  = lk_pfn  | pfn_q[i];
            lk_attr = lk_attr | attr_q[i];
         end
      end
   end

   assign any_hit     = |match;
   assign lk_hit      = lk_valid && any_hit && (!pend_q || cfg_hit_under_miss);
   assign lk_miss     = lk_valid && !lk_hit;
   assign start_miss  = lk_miss && !pend_q;
   assign fill_take   = fill_valid && pend_q;
   assign fill_killed = fl_act
                        && ((pend_vpn_q & fl_mask) == (fl_key & fl_mask))
                        && (!fl_asid_chk || (pend_asid_q == fl_asid));
   assign install     = fill_take && !fill_killed;

   iotlb_victim_sel #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W),
      .CNT_W     (CNT_W)
   ) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_valid (v_q),
      .eff_lines  (eff_lines),
      .alloc      (install),
      .victim     (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         v_q <= v_q & ~kill;
         if (install) v_q[victim] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (install) begin
         tag_vpn_q[victim]  <= pend_vpn_q;
         tag_asid_q[victim] <= pend_asid_q;
         pfn_q[victim]      <= fill_pfn;
         attr_q[victim]     <= fill_attr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_vpn_q  <= '0;
         pend_asid_q <= '0;
      end else if (start_miss) begin
         pend_q      <= 1'b1;
         pend_vpn_q  <= lk_vpn;
         pend_asid_q <= lk_asid;
      end else if (fill_take) begin
         pend_q      <= 1'b0;
      end
   end

   assign fr_valid = pend_q;
   assign fr_vpn   = pend_vpn_q;
   assign fr_asid  = pend_asid_q;
endmodule

// File: rtl/iotlb_asid_checker.sv
module iotlb_asid_checker #(
   parameter int ASID_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_hit_under_miss,
   input logic              lk_valid,
   input logic [19:0]       lk_vpn,
   input logic [ASID_W-1:0] lk_asid,
   input logic              lk_hit,
   input logic              lk_miss,
   input logic              fr_valid,
   input logic [19:0]       fr_vpn,
   input logic [ASID_W-1:0] fr_asid,
   input logic              fill_valid,
   input logic              cmd_we,
   input logic [31:0]       cmd_wdata
);
   assert_hit_needs_lookup_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_valid);

   assert_hit_miss_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss));

   assert_request_after_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_miss && !fr_valid) |=> (fr_valid && fr_vpn == $past(lk_vpn) && fr_asid == $past(lk_asid)));

   assert_request_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_valid && !fill_valid) |=> (fr_valid && $stable(fr_vpn) && $stable(fr_asid)));

   assert_fill_retires_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_valid && fill_valid) |=> !fr_valid);

   assert_blocked_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_valid && !cfg_hit_under_miss) |-> !lk_hit);

   assert_flush_all_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_wdata[1:0] == 2'b00 && !cmd_wdata[31]) |=> !lk_hit);
endmodule

bind iotlb_asid iotlb_asid_checker #(.ASID_W(ASID_W)) u_chk (
   .clk                (clk),
   .rst_n              (rst_n),
   .cfg_hit_under_miss (cfg_hit_under_miss),
   .lk_valid           (lk_valid),
   .lk_vpn             (lk_vpn),
   .lk_asid            (lk_asid),
   .lk_hit             (lk_hit),
   .lk_miss            (lk_miss),
   .fr_valid           (fr_valid),
   .fr_vpn             (fr_vpn),
   .fr_asid            (fr_asid),
   .fill_valid         (fill_valid),
   .cmd_we             (cmd_we),
   .cmd_wdata          (cmd_wdata)
);

// File: tb/iotlb_asid_bench.sv
`timescale 1ns/1ps
module iotlb_asid_bench;
   localparam int NL   = 8;
   localparam int AW   = 7;
   localparam int PW   = 20;
   localparam int CW   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_active_lines = CW'(NL);
   logic          cfg_hit_under_miss = 1'b1;
   logic          lk_valid = 1'b0;
   logic [19:0]   lk_vpn = '0;
   logic [AW-1:0] lk_asid = '0;
   logic          lk_hit, lk_miss;
   logic [PW-1:0] lk_pfn;
   logic [2:0]    lk_attr;
   logic          fr_valid;
   logic [19:0]   fr_vpn;
   logic [AW-1:0] fr_asid;
   logic          fill_valid = 1'b0;
   logic [PW-1:0] fill_pfn = '0;
   logic [2:0]    fill_attr = '0;
   logic          cmd_we = 1'b0;
   logic [31:0]   cmd_wdata = '0;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   iotlb_asid u_iotlb_asid (
      .clk(clk), .rst_n(rst_n),
      .cfg_active_lines(cfg_active_lines), .cfg_hit_under_miss(cfg_hit_under_miss),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn), .lk_attr(lk_attr),
      .fr_valid(fr_valid), .fr_vpn(fr_vpn), .fr_asid(fr_asid),
      .fill_valid(fill_valid), .fill_pfn(fill_pfn), .fill_attr(fill_attr),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata)
   );

   function automatic logic [PW-1:0] pfn_of(input logic [19:0] vpn);
      return PW'(vpn ^ 20'hA5A5A);
   endfunction

   function automatic logic [2:0] attr_of(input logic [19:0] vpn);
      return vpn[2:0] ^ 3'b101;
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input int lines);
      @(negedge clk);
      rst_n = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0; cmd_we = 1'b0;
      cfg_active_lines = CW'(lines); cfg_hit_under_miss = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic probe(input logic [19:0] vpn, input logic [AW-1:0] asid,
                        output logic hit, output logic [PW-1:0] pfn, output logic [2:0] attr);
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = vpn; lk_asid = asid;
      #1;
      hit = lk_hit; pfn = lk_pfn; attr = lk_attr;
      @(posedge clk);
      #1 lk_valid = 1'b0;
   endtask

   task automatic expect_hit(input string req, input logic [19:0] vpn, input logic [AW-1:0] asid);
      logic h; logic [PW-1:0] p; logic [2:0] a;
      probe(vpn, asid, h, p, a);
      check(req, "hit", 32'(h), 32'd1);
      check(req, "pfn", 32'(p), 32'(pfn_of(vpn)));
      check(req, "attr", 32'(a), 32'(attr_of(vpn)));
   endtask

   task automatic expect_miss(input string req, input logic [19:0] vpn, input logic [AW-1:0] asid);
      logic h; logic [PW-1:0] p; logic [2:0] a;
      probe(vpn, asid, h, p, a);
      check(req, "hit", 32'(h), 32'd0);
   endtask

   task automatic serve_fill(input logic [19:0] vpn);
      @(negedge clk);
      fill_valid = 1'b1; fill_pfn = pfn_of(vpn); fill_attr = attr_of(vpn);
      @(posedge clk);
      #1 fill_valid = 1'b0;
   endtask

   task automatic install(input logic [19:0] vpn, input logic [AW-1:0] asid);
      expect_miss("R2", vpn, asid);
      @(negedge clk);
      check("R2", "fr_valid", 32'(fr_valid), 32'd1);
      check("R2", "fr_vpn", 32'(fr_vpn), 32'(vpn));
      check("R2", "fr_asid", 32'(fr_asid), 32'(asid));
      serve_fill(vpn);
   endtask

   task automatic flush(input logic [31:0] cmd);
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = cmd;
      @(posedge clk);
      #1 cmd_we = 1'b0;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic h; logic [PW-1:0] p; logic [2:0] a;

      // R12: reset state
      do_reset(NL);
      @(negedge clk);
      check("R12", "fr_valid", 32'(fr_valid), 32'd0);
      lk_valid = 1'b1; lk_vpn = 20'h00000; lk_asid = '0;
      #1 check("R12", "hit", 32'(lk_hit), 32'd0);
      check("R12", "miss", 32'(lk_miss), 32'd1);
      @(posedge clk); #1 lk_valid = 1'b0;

      // R1/R2: fill all lines, each with its own identifier
      do_reset(NL);
      for (int i = 0; i < NL; i++) install(20'h30000 + 20'(i * 'h1111), AW'(i));
      for (int i = 0; i < NL; i++) expect_hit("R1", 20'h30000 + 20'(i * 'h1111), AW'(i));
      for (int i = 0; i < NL; i++) expect_miss("R1", 20'h30000 + 20'(i * 'h1111), AW'(i + 64));

      // R3: hit under miss
      do_reset(NL);
      install(20'h0AAAA, 7'd4);
      expect_miss("R3", 20'h0BBBB, 7'd4);
      expect_hit("R3", 20'h0AAAA, 7'd4);
      cfg_hit_under_miss = 1'b0;
      expect_miss("R3", 20'h0AAAA, 7'd4);
      expect_miss("R3", 20'h0CCCC, 7'd4);
      @(negedge clk);
      check("R3", "fr_vpn kept", 32'(fr_vpn), 32'h0BBBB);
      cfg_hit_under_miss = 1'b1;
      serve_fill(20'h0BBBB);
      expect_hit("R2", 20'h0BBBB, 7'd4);

      // R4..R9: invalidation modes
      do_reset(NL);
      install(20'h12345, 7'd5);
      install(20'h12346, 7'd5);
      install(20'h12349, 7'd5);
      install(20'h12345, 7'd9);
      install(20'h55000, 7'd5);
      install(20'h55000, 7'd3);
      flush(32'h8501_2345);   // R8: reserved mode, same fields
      expect_hit("R8", 20'h12345, 7'd5);
      expect_hit("R8", 20'h12346, 7'd5);
      expect_hit("R8", 20'h12349, 7'd5);
      expect_hit("R8", 20'h12345, 7'd9);
      expect_hit("R8", 20'h55000, 7'd5);
      expect_hit("R8", 20'h55000, 7'd3);
      flush(32'h8501_2347);   // R6 + R7: group of 0x12345000, identifier 5
      expect_miss("R6", 20'h12345, 7'd5);
      expect_miss("R6", 20'h12346, 7'd5);
      expect_hit("R6", 20'h12349, 7'd5);
      expect_hit("R7", 20'h12345, 7'd9);
      expect_hit("R6", 20'h55000, 7'd5);
      flush(32'h0001_2002);   // R5: section 0x48, any identifier
      expect_miss("R5", 20'h12349, 7'd5);
      expect_miss("R5", 20'h12345, 7'd9);
      expect_hit("R5", 20'h55000, 7'd5);
      expect_hit("R5", 20'h55000, 7'd3);
      flush(32'h8500_0000);   // R7: all lines of identifier 5
      expect_miss("R7", 20'h55000, 7'd5);
      expect_hit("R7", 20'h55000, 7'd3);
      // R9 + R4: timing of a full invalidation
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = 32'h0000_0000;
      lk_valid = 1'b1; lk_vpn = 20'h55000; lk_asid = 7'd3;
      #1 check("R9", "hit in write cycle", 32'(lk_hit), 32'd1);
      @(posedge clk);
      #1 cmd_we = 1'b0;
      #1 check("R9", "hit cycle after write", 32'(lk_hit), 32'd0);
      @(posedge clk);
      #1 lk_valid = 1'b0;
      expect_miss("R4", 20'h55000, 7'd3);

      // R10: fill alongside a non-covering command is kept
      do_reset(NL);
      expect_miss("R10", 20'h07777, 7'd2);
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = 32'h8700_0000;
      @(posedge clk);
      #1 cmd_we = 1'b0;
      fill_valid = 1'b1; fill_pfn = pfn_of(20'h07777); fill_attr = attr_of(20'h07777);
      @(posedge clk);
      #1 fill_valid = 1'b0;
      check("R10", "fr_valid retired", 32'(fr_valid), 32'd0);
      expect_hit("R10", 20'h07777, 7'd2);
      // R10: fill alongside a covering command is dropped
      do_reset(NL);
      expect_miss("R10", 20'h07777, 7'd2);
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = 32'h0000_0000;
      @(posedge clk);
      #1 cmd_we = 1'b0;
      fill_valid = 1'b1; fill_pfn = pfn_of(20'h07777); fill_attr = attr_of(20'h07777);
      @(posedge clk);
      #1 fill_valid = 1'b0;
      check("R10", "fr_valid retired", 32'(fr_valid), 32'd0);
      expect_miss("R10", 20'h07777, 7'd2);

      // R11: sweep of active line count
      for (int n = 1; n <= NL; n++) begin
         do_reset(n);
         for (int k = 0; k <= n + 1; k++) install(20'h00100 + 20'(k), 7'd1);
         for (int k = 2; k <= n + 1; k++) expect_hit("R11", 20'h00100 + 20'(k), 7'd1);
         expect_miss("R11", 20'h00100, 7'd1);
         expect_miss("R11", 20'h00101, 7'd1);
      end

      probe(20'h0, '0, h, p, a);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule